// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 2-kbit serial EEPROM slave for a three-wire bus made of a chip-select, a serial clock and a data input, with a separate data output that can be tri-stated. The host raises chip-select and clocks in an instruction: a start bit of 1, a two-bit opcode and an address field. Write-type instructions then carry a data word. Reads return one dummy zero bit and then the addressed word, MSB first. While chip-select stays high and the clock keeps running, further words follow at ascending addresses, and the address wraps at the end of the array.

A strap input selects the word width. When high, the array is 128 words of 16 bits. When low, it is 256 bytes. Programming is guarded by a write-enable latch. A complete write, erase, erase-all or write-all is committed on the falling edge of chip-select and then runs as a self-timed cycle that needs no serial clock. The host sees the cycle's progress on the data output when it reselects the device. The three bus inputs are resynchronized into the system clock, so the serial clock must run well below the system clock. The program time is a parameter counted in system clocks.

Top module: `ser_eeprom_slave`

## Requirements
- R1: After reset, do_oe_o is low, every location reads as all ones, and the device is write-disabled.
- R2: The word width and the address field are set by org_i. With org_i=1 the address field is 8 bits, words are 16 bits, and the low 7 address bits select the word. With org_i=0 the address field is 9 bits, the data is 8 bits, and the low 8 address bits select a byte: byte address b is word b>>1, bits 15:8 when b[0]=1 and bits 7:0 when b[0]=0. In both modes the top address bit is ignored.
- R3: Bits are sent MSB first. Opcode 10 is a read. On the SK rising edge that samples the last address bit, DO is driven (do_oe_o=1) with a dummy 0. Each following SK rising edge presents the next data bit, MSB first.
- R4: In a continued read, the next word follows at address+1 with no dummy bit. The address wraps from the last location to 0 (127 in x16, 255 in x8).
- R5: Opcode 01 is a write. Opcode 11 is an erase. Opcode 00 takes a sub-code from the two uppermost address bits: 11 enables programming, 00 disables it, 10 is erase-all and 01 is write-all. No programming cycle starts while the device is disabled. Reads work in either state.
- R6: A complete write or erase starts its cycle on the falling edge of chip-select. A write replaces the whole word without a prior erase. An erase sets the word to all ones.
- R7: Erase-all sets every location to all ones. Write-all stores its data word in every location.
- R8: After a cycle has started, raising chip-select drives DO low while the cycle is busy and high once it is ready. Sampling DI=1 on an SK rising edge releases DO (do_oe_o=0) and consumes that bit.
- R9: A cycle starts only when chip-select falls after a complete instruction. A chip-select drop earlier than that has no effect. Instructions clocked in while a cycle is busy are ignored.
- R10: The self-timed cycle lasts PROG_CYCLES system clocks. Its result becomes readable when it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in, sampled on SK rising edge |
| org_i | input | 1 | Organization strap: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data / ready-busy out |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
A corrupted shift counter or opcode register shows up at the latest on the first read that follows. In that case the dummy zero moves, a word comes out shifted by a bit, or the wrong word is selected. A faulty write-enable latch or commit condition shows at once when the host reselects: the busy status appears or does not appear on DO, and a later read returns data that is changed or unchanged. A wrong cycle timer shows within one program time, as a ready indication that arrives early or late.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL
  } prog_op_e;

  typedef enum logic [3:0] {
    ST_OFF, ST_LISTEN, ST_OPC, ST_ADDR, ST_DATA,
    ST_READ, ST_HOLD, ST_STAT, ST_IGNORE
  } ctl_state_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_EN   = 2'b11;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/eep_timer.sv
module eep_timer #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 128,
  localparam int AW    = $clog2(WORDS),
  localparam int BW    = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o,
  input  logic              start_i,
  input  prog_op_e          op_i,
  input  logic [AW:0]       addr_i,
  input  logic              x16_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_i
);
  logic [DATA_W-1:0] mem_q [WORDS];
  prog_op_e          op_q;
  logic [AW:0]       addr_q;
  logic              x16_q;
  logic [DATA_W-1:0] data_q;

  logic [AW-1:0]     widx;
  logic              hi_sel;
  logic [DATA_W-1:0] fill;

  assign rd_word_o = mem_q[rd_idx_i];
  assign widx      = x16_q ? addr_q[AW-1:0] : addr_q[AW:1];
  assign hi_sel    = addr_q[0];
  assign fill      = x16_q ? data_q : {data_q[BW-1:0], data_q[BW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
      op_q   <= OP_NONE;
      addr_q <= '0;
      x16_q  <= 1'b1;
      data_q <= '0;
    end else begin
      if (start_i) begin
        op_q   <= op_i;
        addr_q <= addr_i;
        x16_q  <= x16_i;
        data_q <= data_i;
      end
      if (done_i) begin
        unique case (op_q)
          OP_WRITE: begin
            if (x16_q)       mem_q[widx]              <= data_q;
            else if (hi_sel) mem_q[widx][DATA_W-1:BW] <= data_q[BW-1:0];
            else             mem_q[widx][BW-1:0]      <= data_q[BW-1:0];
          end
          OP_ERASE: begin
            if (x16_q)       mem_q[widx]              <= '1;
            else if (hi_sel) mem_q[widx][DATA_W-1:BW] <= '1;
            else             mem_q[widx][BW-1:0]      <= '1;
          end
          OP_ERAL: for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
          OP_WRAL: for (int i = 0; i < WORDS; i++) mem_q[i] <= fill;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 7,
  localparam int BW    = DATA_W / 2,
  localparam int CNT_W = $clog2(DATA_W + AW + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              x16_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [AW-1:0]     rd_idx_o,
  output logic              start_o,
  output prog_op_e          op_o,
  output logic [AW:0]       addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wen_o,
  output logic              do_o,
  output logic              do_oe_o
);
  ctl_state_e        state_q;
  logic              sk_q;
  logic [CNT_W-1:0]  cnt_q, rd_cnt_q;
  logic [1:0]        opc_q;
  logic [AW:0]       addr_q, rd_addr_q;
  logic [DATA_W-1:0] data_q, shreg_q;
  prog_op_e          op_q;
  logic              wen_q, stat_q, do_q, oe_q;

  logic              sk_rise;
  logic [AW+1:0]     a_n;
  logic [1:0]        sub;
  logic [AW:0]       first_addr, next_addr, look;
  logic [BW-1:0]     byte_sel;
  logic [DATA_W-1:0] load_val;
  logic [CNT_W-1:0]  wlen, flen;

  assign sk_rise    = sk_i & ~sk_q;
  assign a_n        = {addr_q, di_i};
  assign sub        = x16_i ? a_n[AW:AW-1] : a_n[AW+1:AW];
  assign first_addr = x16_i ? {1'b0, a_n[AW-1:0]} : a_n[AW:0];
  assign next_addr  = x16_i ? {1'b0, AW'(rd_addr_q[AW-1:0] + 1'b1)}
                            : (AW+1)'(rd_addr_q + 1'b1);
  assign look       = (state_q == ST_ADDR) ? first_addr : next_addr;
  assign rd_idx_o   = x16_i ? look[AW-1:0] : look[AW:1];
  assign byte_sel   = look[0] ? rd_word_i[DATA_W-1:BW] : rd_word_i[BW-1:0];
  assign load_val   = x16_i ? rd_word_i : {byte_sel, {BW{1'b0}}};
  assign wlen       = x16_i ? CNT_W'(DATA_W) : CNT_W'(BW);
  assign flen       = x16_i ? CNT_W'(AW + 1) : CNT_W'(AW + 2);

  // commit on deselect of a complete, enabled programming instruction
  assign start_o = (state_q == ST_HOLD) && !cs_i && wen_q &&
                   (op_q != OP_NONE) && !busy_i;
  assign op_o    = op_q;
  assign addr_o  = x16_i ? {1'b0, addr_q[AW-1:0]} : addr_q;
  assign data_o  = data_q;
  assign wen_o   = wen_q;
  assign do_o    = do_q;
  assign do_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      sk_q      <= 1'b0;
      cnt_q     <= '0;
      rd_cnt_q  <= '0;
      opc_q     <= '0;
      addr_q    <= '0;
      rd_addr_q <= '0;
      data_q    <= '0;
      shreg_q   <= '0;
      op_q      <= OP_NONE;
      wen_q     <= 1'b0;
      stat_q    <= 1'b0;
      do_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      sk_q <= sk_i;
      if (!cs_i) begin
        state_q <= ST_OFF;
        oe_q    <= 1'b0;
        if (start_o) stat_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_OFF: begin
            if (stat_q) begin
              state_q <= ST_STAT;
              oe_q    <= 1'b1;
              do_q    <= ~busy_i;
            end else if (busy_i) begin
              state_q <= ST_IGNORE;
            end else begin
              state_q <= ST_LISTEN;
            end
          end
          ST_STAT: begin
            do_q <= ~busy_i;
            if (sk_rise && di_i) begin
              stat_q  <= 1'b0;
              oe_q    <= 1'b0;
              state_q <= busy_i ? ST_IGNORE : ST_LISTEN;
            end
          end
          ST_LISTEN: begin
            if (sk_rise && di_i) begin
              state_q <= ST_OPC;
              cnt_q   <= '0;
              op_q    <= OP_NONE;
            end
          end
          ST_OPC: begin
            if (sk_rise) begin
              opc_q <= {opc_q[0], di_i};
              if (cnt_q == CNT_W'(1)) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_ADDR: begin
            if (sk_rise) begin
              addr_q <= a_n[AW:0];
              if (cnt_q == flen - 1'b1) begin
                cnt_q <= '0;
                unique case (opc_q)
                  OPC_READ: begin
                    rd_addr_q <= first_addr;
                    shreg_q   <= load_val;
                    rd_cnt_q  <= wlen;
                    do_q      <= 1'b0;
                    oe_q      <= 1'b1;
                    state_q   <= ST_READ;
                  end
                  OPC_WRITE: begin
                    op_q    <= OP_WRITE;
                    state_q <= ST_DATA;
                  end
                  OPC_ERASE: begin
                    op_q    <= OP_ERASE;
                    state_q <= ST_HOLD;
                  end
                  default: begin
                    state_q <= ST_HOLD;
                    unique case (sub)
                      SUB_EN:   wen_q <= 1'b1;
                      SUB_DIS:  wen_q <= 1'b0;
                      SUB_ERAL: op_q  <= OP_ERAL;
                      default: begin
                        op_q    <= OP_WRAL;
                        state_q <= ST_DATA;
                      end
                    endcase
                  end
                endcase
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (sk_rise) begin
              data_q <= {data_q[DATA_W-2:0], di_i};
              if (cnt_q == wlen - 1'b1) state_q <= ST_HOLD;
              else                      cnt_q   <= cnt_q + 1'b1;
            end
          end
          ST_READ: begin
            if (sk_rise) begin
              if (rd_cnt_q == '0) begin
                rd_addr_q <= next_addr;
                do_q      <= load_val[DATA_W-1];
                shreg_q   <= {load_val[DATA_W-2:0], 1'b0};
                rd_cnt_q  <= wlen - 1'b1;
              end else begin
                do_q     <= shreg_q[DATA_W-1];
                shreg_q  <= {shreg_q[DATA_W-2:0], 1'b0};
                rd_cnt_q <= rd_cnt_q - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
  import eep_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int WORDS       = 128,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int AW = $clog2(WORDS);

  logic              cs_s, sk_s, di_s;
  logic              busy, done, start, wen;
  prog_op_e          op;
  logic [AW:0]       paddr;
  logic [DATA_W-1:0] pdata, rd_word;
  logic [AW-1:0]     rd_idx;

  eep_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sk_i, di_i}),
    .q_o    ({cs_s, sk_s, di_s})
  );

  eep_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_s),
    .sk_i      (sk_s),
    .di_i      (di_s),
    .x16_i     (org_i),
    .busy_i    (busy),
    .rd_word_i (rd_word),
    .rd_idx_o  (rd_idx),
    .start_o   (start),
    .op_o      (op),
    .addr_o    (paddr),
    .data_o    (pdata),
    .wen_o     (wen),
    .do_o      (do_o),
    .do_oe_o   (do_oe_o)
  );

  eep_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  eep_array #(.DATA_W(DATA_W), .WORDS(WORDS)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_word_o (rd_word),
    .start_i   (start),
    .op_i      (op),
    .addr_i    (paddr),
    .x16_i     (org_i),
    .data_i    (pdata),
    .done_i    (done)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s_i,
  input logic busy_i,
  input logic wen_i,
  input logic do_i,
  input logic do_oe_i
);
  int unsigned bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt_q <= 0;
    else if (busy_i) bcnt_q <= bcnt_q + 1;
    else             bcnt_q <= 0;
  end

  // R8
  oe_off_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> !do_oe_i);

  // R8
  busy_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && do_oe_i) |-> !do_i);

  // R5
  start_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wen_i));

  // R9
  start_on_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(!cs_s_i));

  // R10
  cycle_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (bcnt_q == PROG_CYCLES));
endmodule

bind ser_eeprom_slave eep_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s_i  (cs_s),
  .busy_i  (busy),
  .wen_i   (wen),
  .do_i    (do_o),
  .do_oe_i (do_oe_o)
);

// File: tb/tb_ser_eeprom_slave.sv
module tb_ser_eeprom_slave;
  localparam int PROG = 1000;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_w, oe_w;

  always #4 clk = ~clk;

  ser_eeprom_slave #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .org_i(org), .do_o(do_w), .do_oe_o(oe_w)
  );

  int n_run = 0, n_fail = 0, cyc = 0, t_fall = 0;
  logic [15:0] model [128];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b;
    tick(HALF);
    sk = 1'b1;
    tick(HALF);
    sk = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cs_down();
    cs = 1'b0;
    di = 1'b0;
    t_fall = cyc;
    tick(2 * HALF);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [8:0] addr, input bit x16);
    sk_bit(1'b1);
    sk_bit(op[1]);
    sk_bit(op[0]);
    for (int i = (x16 ? 7 : 8); i >= 0; i--) sk_bit(addr[i]);
  endtask

  task automatic prog(input logic [1:0] op, input logic [8:0] addr,
                      input logic [15:0] data, input bit x16, input bit has_data);
    cs_up();
    hdr(op, addr, x16);
    if (has_data)
      for (int i = (x16 ? 15 : 7); i >= 0; i--) sk_bit(data[i]);
    cs_down();
  endtask

  function automatic logic [7:0] exp_byte(input int ba);
    logic [15:0] w;
    w = model[ba >> 1];
    return ba[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic read_seq(input logic [8:0] addr, input int n, input bit x16,
                          input string req);
    int base, wl;
    base = x16 ? int'(addr[6:0]) : int'(addr[7:0]);
    wl   = x16 ? 16 : 8;
    cs_up();
    hdr(2'b10, addr, x16);
    check(oe_w === 1'b1 && do_w === 1'b0, req, "dummy zero", {oe_w, do_w}, 2'b10);
    for (int w = 0; w < n; w++) begin
      logic [15:0] got, expv;
      bit oe_ok;
      got = '0;
      oe_ok = 1'b1;
      for (int b = 0; b < wl; b++) begin
        sk_bit(1'b0);
        got = {got[14:0], do_w};
        if (oe_w !== 1'b1) oe_ok = 1'b0;
      end
      expv = x16 ? model[(base + w) % 128] : {8'h00, exp_byte((base + w) % 256)};
      check(oe_ok && got === expv, req, "read word", got, expv);
    end
    cs_down();
  endtask

  task automatic wait_ready(input string req);
    int k, el;
    cs_up();
    check(oe_w === 1'b1 && do_w === 1'b0, "R8", "busy status", {oe_w, do_w}, 2'b10);
    k = 0;
    while (do_w !== 1'b1 && k < 3 * PROG) begin
      tick(1);
      k++;
    end
    el = cyc - t_fall;
    check(oe_w === 1'b1 && do_w === 1'b1, "R8", "ready status", {oe_w, do_w}, 2'b11);
    check(el >= PROG && el <= PROG + 12, "R10", "cycle length", el, PROG);
    sk_bit(1'b1);
    check(oe_w === 1'b0, req, "status release", oe_w, 0);
    cs_down();
  endtask

  task automatic t_reset();
    check(oe_w === 1'b0, "R1", "reset oe", oe_w, 0);
    read_seq(9'd5, 1, 1'b1, "R1");
    read_seq(9'd0, 1, 1'b1, "R3");
  endtask

  task automatic t_wen_gate();
    prog(2'b01, 9'd5, 16'h1234, 1'b1, 1'b1);
    cs_up();
    check(oe_w === 1'b0, "R5", "no cycle while disabled", oe_w, 0);
    cs_down();
    read_seq(9'd5, 1, 1'b1, "R5");
  endtask

  task automatic t_write();
    prog(2'b00, 9'h0C0, 16'h0, 1'b1, 1'b0);
    prog(2'b01, 9'd5, 16'h1234, 1'b1, 1'b1);
    wait_ready("R8");
    model[5] = 16'h1234;
    read_seq(9'd5, 1, 1'b1, "R6");
    prog(2'b01, 9'd6, 16'hABCD, 1'b1, 1'b1);
    wait_ready("R8");
    model[6] = 16'hABCD;
    prog(2'b01, 9'd5, 16'h0F0F, 1'b1, 1'b1);
    wait_ready("R8");
    model[5] = 16'h0F0F;
    read_seq(9'd5, 2, 1'b1, "R4");
  endtask

  task automatic t_wrap();
    prog(2'b01, 9'd127, 16'hBEEF, 1'b1, 1'b1);
    wait_ready("R8");
    model[127] = 16'hBEEF;
    read_seq(9'd127, 2, 1'b1, "R4");
    read_seq(9'h0FF, 1, 1'b1, "R2");
  endtask

  task automatic t_erase();
    prog(2'b11, 9'd5, 16'h0, 1'b1, 1'b0);
    wait_ready("R8");
    model[5] = 16'hFFFF;
    read_seq(9'd5, 1, 1'b1, "R6");
  endtask

  task automatic t_x8();
    org = 1'b0;
    tick(4);
    prog(2'b01, 9'h00D, 16'h0055, 1'b0, 1'b1);
    wait_ready("R8");
    model[6][15:8] = 8'h55;
    read_seq(9'h00C, 2, 1'b0, "R2");
    read_seq(9'h10D, 1, 1'b0, "R2");
    read_seq(9'h0FF, 2, 1'b0, "R4");
    org = 1'b1;
    tick(4);
    read_seq(9'd6, 1, 1'b1, "R2");
  endtask

  task automatic t_abort();
    cs_up();
    hdr(2'b01, 9'd6, 1'b1);
    for (int i = 0; i < 8; i++) sk_bit(1'b0);
    cs_down();
    cs_up();
    check(oe_w === 1'b0, "R9", "no cycle after early drop", oe_w, 0);
    cs_down();
    read_seq(9'd6, 1, 1'b1, "R9");
  endtask

  task automatic t_busy_ignore();
    prog(2'b01, 9'd10, 16'h1111, 1'b1, 1'b1);
    cs_up();
    check(oe_w === 1'b1 && do_w === 1'b0, "R8", "busy seen", {oe_w, do_w}, 2'b10);
    sk_bit(1'b1);
    check(oe_w === 1'b0, "R8", "release while busy", oe_w, 0);
    hdr(2'b01, 9'd11, 1'b1);
    for (int i = 15; i >= 0; i--) sk_bit(1'b0);
    cs_down();
    tick(PROG + 20);
    cs_up();
    check(oe_w === 1'b0, "R9", "ignored instruction starts nothing", oe_w, 0);
    cs_down();
    model[10] = 16'h1111;
    read_seq(9'd10, 2, 1'b1, "R9");
  endtask

  task automatic t_all();
    prog(2'b00, 9'h040, 16'hA5A5, 1'b1, 1'b1);
    wait_ready("R8");
    for (int i = 0; i < 128; i++) model[i] = 16'hA5A5;
    read_seq(9'd126, 3, 1'b1, "R7");
    prog(2'b00, 9'h080, 16'h0, 1'b1, 1'b0);
    wait_ready("R8");
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    read_seq(9'd0, 2, 1'b1, "R7");
    read_seq(9'd64, 1, 1'b1, "R7");
  endtask

  task automatic t_ewds();
    prog(2'b00, 9'h000, 16'h0, 1'b1, 1'b0);
    prog(2'b01, 9'd3, 16'h0001, 1'b1, 1'b1);
    cs_up();
    check(oe_w === 1'b0, "R5", "no cycle after disable", oe_w, 0);
    cs_down();
    read_seq(9'd3, 1, 1'b1, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_wen_gate();
    t_write();
    t_wrap();
    t_erase();
    t_x8();
    t_abort();
    t_busy_ignore();
    t_all();
    t_ewds();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule